// File: doc/BRIEF.md
# Input change-of-state interrupt logic

This block watches four general-purpose input pins and reports when any of them changes level. Each pin passes through a two-flop synchronizer and is then sampled on a strobe that a free-running divider raises once every `SAMPLE_DIV` clock cycles. A new level is accepted only after two consecutive strobes have seen it. Every accepted change sets a sticky delta flag for that pin.

Software reads the deltas, together with the current filtered pin levels, from a change register. That read clears all four deltas. A 4-bit enable register chooses which deltas may raise a single summary bit in a status register. The summary bit is gated by a mask bit to drive an active-high interrupt line.

Access is through a simple synchronous register port. The read data is combinational from the current state. A read or write takes effect at the clock edge where `bus_sel` is high.

Top module: `pin_delta_irq`

## Requirements
- R1: After reset, the change register, the enable register, the status register and the mask register all read 0x00, and `irq_o` is low.
- R2: The change register is at address 0. Bits 7:4 hold the current filtered levels, with pin 0 at bit 4. Bits 3:0 hold the delta flags, with pin 0 at bit 0. A delta flag is set when the filtered level of its pin changes, in either direction.
- R3: The filtered level of a pin changes only after the new level has been seen on two consecutive sample strobes. An input pulse shorter than one strobe period leaves both the level and the delta unchanged.
- R4: Delta flags stay set until the change register is read. A read of the change register clears all four delta flags.
- R5: If a new change is accepted in the same cycle as a read of the change register, its delta flag is set after that read and is not lost.
- R6: The enable register is at address 1, with bit n enabling pin n. Its bits 7:4 read as 0. The status register is at address 2, and its bit 7 is 1 while any set delta flag has its enable bit at 1. Delta flags whose enable bit is 0 do not affect status bit 7.
- R7: A write to the enable register recomputes status bit 7 from the delta flags already latched. Enabling a latched delta sets the bit, and disabling it clears the bit.
- R8: A read of the change register clears status bit 7, unless an enabled change is accepted in the same cycle.
- R9: The mask register is at address 3. Only bit 7 is stored, and the other bits read as 0. `irq_o` is high exactly when status bit 7 and mask bit 7 are both 1.
- R10: Writes to the change register and to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 4 | Asynchronous general-purpose input pins, bit n is pin n |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Active-high interrupt |

## Verification
The bench sends a glitch shorter than one strobe period. A filter that accepts a level after a single strobe would report a phantom delta. It also reads the change register on every cycle while a change is arriving, so some read always coincides with the change being accepted. A design in which the clear beats the new change would never show that delta. It toggles the enable register over a delta that is already latched. This exposes a status bit that only updates when a new change arrives. Writes aimed at the read-only registers catch decoders that let the change or status state be overwritten.

// File: rtl/pdi_pkg.sv
// Shared constants for the input change-of-state interrupt block.
// Assumes a fixed four-pin register layout on an 8-bit data bus.
package pdi_pkg;
    localparam int NUM_PINS = 4;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;

    typedef logic [ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t ADDR_CHG  = 2'd0;
    localparam reg_addr_t ADDR_EN   = 2'd1;
    localparam reg_addr_t ADDR_STAT = 2'd2;
    localparam reg_addr_t ADDR_MASK = 2'd3;

    // bit position of the summary bit in status and mask registers
    localparam int SUM_BIT = 7;
endpackage

// File: rtl/pdi_tick_gen.sv
// Sample strobe generator: one-cycle pulse every DIV clock cycles.
// Assumes DIV >= 2. Free-running from reset.
module pdi_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // count cycles and fire the strobe on the last count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= (cnt_q == LAST);
            cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pdi_pin_filter.sv
// Per-pin front end: two-flop synchronizer, then a level filter that
// accepts a new level only when two consecutive strobes agree on it.
// Emits a one-cycle change pulse in the cycle the level updates.
// Assumes the pin level is 0 at reset.
module pdi_pin_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic tick,
    output logic level_o,
    output logic chg_o
);
    logic meta_q, sync_q, cand_q;
    logic accept;

    // bring the asynchronous pin into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
        end
    end

    // a new level is accepted when this strobe matches the previous one
    assign accept = tick && (sync_q == cand_q) && (sync_q != level_o);

    // hold the candidate, the accepted level and the change pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q  <= 1'b0;
            level_o <= 1'b0;
            chg_o   <= 1'b0;
        end else begin
            chg_o <= accept;
            if (tick) cand_q <= sync_q;
            if (accept) level_o <= sync_q;
        end
    end
endmodule

// File: rtl/pdi_delta_bank.sv
// Sticky delta flags, per-pin enable register and the summary status bit.
// A clear request drops all flags; a change pulse in the same cycle
// still sets its flag. Status is derived from the latched flags and the
// enables, so an enable write takes effect without a new change.
module pdi_delta_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] chg_i,
    input  logic         clr_i,
    input  logic         en_we,
    input  logic [N-1:0] en_wdata,
    output logic [N-1:0] delta_o,
    output logic [N-1:0] en_o,
    output logic         sum_o
);
    // one sticky flag per pin
    for (genvar g = 0; g < N; g++) begin : g_flag
        // set on change, clear on read; the change wins a tie
        always_ff @(posedge clk) begin
            if (!rst_n)         delta_o[g] <= 1'b0;
            else if (chg_i[g])  delta_o[g] <= 1'b1;
            else if (clr_i)     delta_o[g] <= 1'b0;
        end
    end

    // enable register
    always_ff @(posedge clk) begin
        if (!rst_n)     en_o <= '0;
        else if (en_we) en_o <= en_wdata;
    end

    // summary: any latched flag whose pin is enabled
    assign sum_o = |(delta_o & en_o);
endmodule

// File: rtl/pin_delta_irq.sv
// Input change-of-state interrupt logic, top level.
// Filters four input pins, latches per-pin change flags, folds enabled
// flags into one status bit and gates it with a mask bit onto irq_o.
// Register port: reads are combinational; side effects at the clock edge.
module pin_delta_irq
    import pdi_pkg::*;
#(
    parameter int SAMPLE_DIV = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_o
);
    localparam int PAD_W = DATA_W - 2 * NUM_PINS;

    logic                tick;
    logic [NUM_PINS-1:0] level;
    logic [NUM_PINS-1:0] pulse;
    logic [NUM_PINS-1:0] delta;
    logic [NUM_PINS-1:0] en;
    logic                isr;
    logic                mask_q;
    logic                rd_chg, we_en, we_mask;
    logic                unused_wbits;

    assign rd_chg  = bus_sel && !bus_wr && (bus_addr == ADDR_CHG);
    assign we_en   = bus_sel &&  bus_wr && (bus_addr == ADDR_EN);
    assign we_mask = bus_sel &&  bus_wr && (bus_addr == ADDR_MASK);
    assign unused_wbits = &{1'b0, bus_wdata[SUM_BIT-1:NUM_PINS]};

    pdi_tick_gen #(.DIV(SAMPLE_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pdi_pin_filter u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (pin_i[p]),
            .tick      (tick),
            .level_o   (level[p]),
            .chg_o     (pulse[p])
        );
    end

    pdi_delta_bank #(.N(NUM_PINS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .chg_i    (pulse),
        .clr_i    (rd_chg),
        .en_we    (we_en),
        .en_wdata (bus_wdata[NUM_PINS-1:0]),
        .delta_o  (delta),
        .en_o     (en),
        .sum_o    (isr)
    );

    // interrupt mask bit
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= 1'b0;
        else if (we_mask) mask_q <= bus_wdata[SUM_BIT];
    end

    // read data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CHG:  bus_rdata = {level, delta};
            ADDR_EN:   bus_rdata = {{(DATA_W - NUM_PINS){1'b0}}, en};
            ADDR_STAT: bus_rdata[SUM_BIT] = isr;
            ADDR_MASK: bus_rdata[SUM_BIT] = mask_q;
            default:   bus_rdata = '0;
        endcase
    end

    // interrupt output
    assign irq_o = isr && mask_q;

    if (PAD_W != 0) begin : g_width_guard
        initial $error("pin_delta_irq: register layout needs DATA_W == 2*NUM_PINS");
    end
endmodule

// File: rtl/pin_delta_irq_chk.sv
// Assertion checker for pin_delta_irq, attached with bind.
// Observes the register-port decode, filter outputs and flag state.
module pin_delta_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_chg,
    input logic       tick,
    input logic [3:0] level,
    input logic [3:0] pulse,
    input logic [3:0] delta,
    input logic [3:0] en,
    input logic       isr,
    input logic       mask_q,
    input logic       irq_o
);
    // R3
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(level));

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_chg |=> ((delta & $past(delta)) == $past(delta)));

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_chg && pulse == 4'b0) |=> (delta == 4'b0));

    // R5
    new_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_chg && pulse != 4'b0) |=> ((delta & $past(pulse)) == $past(pulse)));

    // R6
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == 4'b0) |-> !isr);

    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_chg && (pulse & en) == 4'b0 && $stable(en)) |=> !isr);

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask_q && isr));
endmodule

bind pin_delta_irq pin_delta_irq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_chg (rd_chg),
    .tick   (tick),
    .level  (level),
    .pulse  (pulse),
    .delta  (delta),
    .en     (en),
    .isr    (isr),
    .mask_q (mask_q),
    .irq_o  (irq_o)
);

// File: tb/pin_delta_irq_tb.sv
// Scoreboard bench: read tasks push expected read data and irq level,
// a negedge monitor pops and compares during each read cycle.
module pin_delta_irq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int SETTLE     = 3 * DIV + 6;

    typedef struct {
        logic [7:0] data;
        logic       irq;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_i = 4'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_o;

    int   checks = 0;
    int   fails  = 0;
    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pin_delta_irq #(.SAMPLE_DIV(DIV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // monitor: compare each scored read against the expected item
    always @(negedge clk) begin
        if (bus_sel && !bus_wr && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (bus_rdata !== e.data || irq_o !== e.irq) begin
                fails++;
                $display("FAIL %s: rdata=%02h irq=%b expected rdata=%02h irq=%b",
                         e.req, bus_rdata, irq_o, e.data, e.irq);
            end
        end
    end

    task automatic rd(input logic [1:0] a, input logic [7:0] d,
                      input logic i, input string req);
        exp_t e;
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        e.data = d; e.irq = i; e.req = req;
        sb_q.push_back(e);
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, 8'h00, 1'b0, "R1 change reg");
        rd(2'd1, 8'h00, 1'b0, "R1 enable reg");
        rd(2'd2, 8'h00, 1'b0, "R1 status reg");
        rd(2'd3, 8'h00, 1'b0, "R1 mask reg");

        // R2 levels and deltas; R6 disabled deltas leave status clear
        pin_i = 4'b0101; settle();
        rd(2'd2, 8'h00, 1'b0, "R6 disabled deltas");
        rd(2'd0, 8'h55, 1'b0, "R2 levels+deltas");
        // R4 read cleared deltas
        rd(2'd0, 8'h50, 1'b0, "R4 clear on read");

        // R3 glitch shorter than a strobe period is ignored
        @(posedge clk); #1 pin_i[3] = 1'b1;
        @(posedge clk); @(posedge clk); #1 pin_i[3] = 1'b0;
        settle();
        rd(2'd0, 8'h50, 1'b0, "R3 glitch ignored");

        // R6 enabled delta sets status
        wr(2'd1, 8'h08);
        pin_i = 4'b1101; settle();
        rd(2'd1, 8'h08, 1'b0, "R6 enable readback");
        rd(2'd2, 8'h80, 1'b0, "R6 status set, R9 masked");
        wr(2'd3, 8'h80);
        rd(2'd2, 8'h80, 1'b1, "R9 irq with mask");

        // R7 enable write recomputes status
        wr(2'd1, 8'h00);
        rd(2'd2, 8'h00, 1'b0, "R7 disable clears");
        wr(2'd1, 8'h08);
        rd(2'd2, 8'h80, 1'b1, "R7 re-enable sets");

        // R10 writes to read-only registers ignored
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h00);
        rd(2'd2, 8'h80, 1'b1, "R10 status after writes");
        rd(2'd0, 8'hD8, 1'b1, "R10 change after writes");
        // R8 change read clears status
        rd(2'd2, 8'h00, 1'b0, "R8 status cleared");
        rd(2'd3, 8'h80, 1'b0, "R9 mask alone no irq");

        // R6 change on a disabled pin
        pin_i = 4'b1100; settle();
        rd(2'd2, 8'h00, 1'b0, "R6 pin0 disabled");
        rd(2'd0, 8'hC1, 1'b0, "R2 falling edge delta");

        // R9 / R6 unused bits read as zero
        wr(2'd3, 8'hFF);
        rd(2'd3, 8'h80, 1'b0, "R9 mask width");
        wr(2'd1, 8'hFF);
        rd(2'd1, 8'h0F, 1'b0, "R6 enable width");

        // R5 back-to-back reads while a change arrives: exactly one shows it
        begin
            int seen = 0;
            @(posedge clk); #1;
            pin_i = 4'b1110;
            bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0;
            for (int k = 0; k < SETTLE; k++) begin
                @(negedge clk);
                if (bus_rdata[1]) seen++;
            end
            @(posedge clk); #1 bus_sel = 1'b0;
            checks++;
            if (seen != 1) begin
                fails++;
                $display("FAIL R5 change during read: seen=%0d expected=1", seen);
            end
        end
        rd(2'd2, 8'h00, 1'b0, "R5 status after burst");
        rd(2'd0, 8'hE0, 1'b0, "R5 levels after burst");

        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule